// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block decides, for every memory access a core issues, whether the access may proceed. It holds a small, fixed set of address windows (eight by default). Each window has a start address, a length in bytes, an access code and an enable bit. The address of each access is compared against all windows at once. The enabled window with the highest index that contains the address decides the outcome. The outcome is a grant, or a fault that keeps the offending address and direction for the exception handler.

Privileged software reloads windows through a one-window-per-cycle write port, typically when it switches from one task to another. An access that falls outside every enabled window faults. So with all windows disabled after reset, nothing is allowed until software has set up a map.

Top module: `mpc_checker`

## Requirements
- R1: After reset all windows are disabled, `rsp_valid`, `rsp_grant`, `rsp_fault`, `flt_addr` and `flt_write` are 0, and any access then faults with `rsp_hit` = 0.
- R2: A window matches an address when it is enabled and base <= address < base + size, with no wrap past the top of the address space. A size of 0 never matches.
- R3: Access codes are two bits. 2'b00 denies every access. 2'b01 grants reads and faults writes. 2'b10 grants reads and writes. 2'b11 is reserved and denies every access.
- R4: When several windows match, the one with the highest index decides, and its index appears on `rsp_idx` with `rsp_hit` = 1.
- R5: An address matched by no enabled window faults, with `rsp_hit` = 0 and `rsp_idx` = 0.
- R6: A disabled window never matches, whatever its base, size and code.
- R7: Every cycle with `acc_valid` = 1 gives `rsp_valid` = 1 on the next cycle, with exactly one of `rsp_grant` or `rsp_fault` high. A cycle without a request gives `rsp_valid`, `rsp_grant` and `rsp_fault` = 0 on the next cycle.
- R8: When `rsp_fault` is high, `flt_addr` and `flt_write` (1 = write) hold the address and direction of that request. Both keep their values through later grants until the next fault.
- R9: A window write with `cfg_we` = 1 is applied at the clock edge, so accesses from the next cycle on see it. An access presented in the same cycle as the write is checked against the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one window |
| cfg_idx | input | IDX_W | Window being written |
| cfg_en | input | 1 | Enable bit for the window |
| cfg_perm | input | 2 | Access code for the window (R3) |
| cfg_base | input | ADDR_W | Start address of the window |
| cfg_size | input | ADDR_W | Length of the window in bytes |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Verdict present, one cycle after the request |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access refused |
| rsp_hit | output | 1 | Some enabled window matched |
| rsp_idx | output | IDX_W | Index of the deciding window |
| flt_addr | output | ADDR_W | Address of the latest faulting access |
| flt_write | output | 1 | Direction of the latest faulting access |

## Verification
The assertions assume that `acc_addr` and `acc_write` are stable whenever `acc_valid` is sampled, and that `cfg_idx` names an existing window. The fault-capture check compares against the previous cycle's address, so it relies on the request fields being meaningful in the cycle before each verdict. The bench drives every input at the falling edge and keeps `cfg_idx` within range. It reads the verdict one full cycle after each request, and it only overlaps a window write with an access in the single test that targets that ordering.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
   typedef enum logic [1:0] {
      PERM_NONE = 2'b00,
      PERM_RO   = 2'b01,
      PERM_RW   = 2'b10,
      PERM_RSVD = 2'b11
   } perm_t;

   function automatic logic perm_allows(input perm_t p, input logic is_write);
      case (p)
         PERM_RO: perm_allows = !is_write;
         PERM_RW: perm_allows = 1'b1;
         default: perm_allows = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/mpc_region_slot.sv
module mpc_region_slot
   import mpc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 3,
   parameter int SLOT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic              cfg_en,
   input  logic [1:0]        cfg_perm,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] cfg_size,
   input  logic [ADDR_W-1:0] chk_addr,
   output logic              match,
   output perm_t             perm
);
   localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(SLOT);

   logic              en_q;
   perm_t             perm_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] size_q;
   logic [ADDR_W-1:0] offset;
   logic              sel;

   assign sel = cfg_we && (cfg_idx == MY_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         perm_q <= PERM_NONE;
         base_q <= '0;
         size_q <= '0;
      end else if (sel) begin
         en_q   <= cfg_en;
         perm_q <= perm_t'(cfg_perm);
         base_q <= cfg_base;
         size_q <= cfg_size;
      end
   end

   assign offset = chk_addr - base_q;
   assign match  = en_q && (chk_addr >= base_q) && (offset < size_q);
   assign perm   = perm_q;

   // R9
   cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel |=> (base_q == $past(cfg_base)) && (size_q == $past(cfg_size)));
endmodule

// File: rtl/mpc_prio_pick.sv
module mpc_prio_pick #(
   parameter int NUM_REG   = 8,
   parameter int IDX_W     = 3,
   parameter bit HIGH_WINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REG-1:0] match_vec,
   output logic               hit,
   output logic [IDX_W-1:0]   idx
);
   generate
      if (HIGH_WINS) begin : g_high
         always_comb begin
            hit = 1'b0;
            idx = '0;
            for (int i = 0; i < NUM_REG; i++) begin
               if (match_vec[i]) begin
                  hit = 1'b1;
                  idx = IDX_W'(i);
               end
            end
         end
      end else begin : g_low
         always_comb begin
            hit = 1'b0;
            idx = '0;
            for (int i = NUM_REG - 1; i >= 0; i--) begin
               if (match_vec[i]) begin
                  hit = 1'b1;
                  idx = IDX_W'(i);
               end
            end
         end
      end
   endgenerate

   // R4
   win_is_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> match_vec[idx]);
   // R5
   miss_means_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (match_vec == '0));
endmodule

// File: rtl/mpc_checker.sv
module mpc_checker
   import mpc_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int NUM_REG   = 8,
   parameter bit HIGH_WINS = 1'b1,
   localparam int IDX_W    = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic              cfg_en,
   input  logic [1:0]        cfg_perm,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] cfg_size,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic              rsp_fault,
   output logic              rsp_hit,
   output logic [IDX_W-1:0]  rsp_idx,
   output logic [ADDR_W-1:0] flt_addr,
   output logic              flt_write
);
   generate
      if (NUM_REG < 2 || NUM_REG > 64) begin : g_bad_count
         $error("mpc_checker: NUM_REG must lie in 2..64");
      end
      if (ADDR_W < 8) begin : g_bad_width
         $error("mpc_checker: ADDR_W must be at least 8");
      end
   endgenerate

   logic [NUM_REG-1:0] match_vec;
   perm_t              perm_arr [NUM_REG];
   logic               win_hit;
   logic [IDX_W-1:0]   win_idx;
   logic               allowed;

   for (genvar g = 0; g < NUM_REG; g++) begin : g_slot
      mpc_region_slot #(
         .ADDR_W (ADDR_W),
         .IDX_W  (IDX_W),
         .SLOT   (g)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (cfg_we),
         .cfg_idx  (cfg_idx),
         .cfg_en   (cfg_en),
         .cfg_perm (cfg_perm),
         .cfg_base (cfg_base),
         .cfg_size (cfg_size),
         .chk_addr (acc_addr),
         .match    (match_vec[g]),
         .perm     (perm_arr[g])
      );
   end

   mpc_prio_pick #(
      .NUM_REG   (NUM_REG),
      .IDX_W     (IDX_W),
      .HIGH_WINS (HIGH_WINS)
   ) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .match_vec (match_vec),
      .hit       (win_hit),
      .idx       (win_idx)
   );

   assign allowed = win_hit && perm_allows(perm_arr[win_idx], acc_write);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_grant <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_idx   <= '0;
         flt_addr  <= '0;
         flt_write <= 1'b0;
      end else begin
         rsp_valid <= acc_valid;
         rsp_grant <= acc_valid && allowed;
         rsp_fault <= acc_valid && !allowed;
         rsp_hit   <= acc_valid && win_hit;
         rsp_idx   <= acc_valid ? win_idx : '0;
         if (acc_valid && !allowed) begin
            flt_addr  <= acc_addr;
            flt_write <= acc_write;
         end
      end
   end

   // R7
   rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_valid);
   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !rsp_valid && !rsp_grant && !rsp_fault);
   // R5
   nohit_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> rsp_fault);
   // R8
   flt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (flt_addr == $past(acc_addr)) && (flt_write == $past(acc_write)));
   // R8
   flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_fault |-> $stable(flt_addr) && $stable(flt_write));
endmodule

// File: tb/mpc_checker_tb.sv
module mpc_checker_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int NV = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_idx = '0;
   logic          cfg_en = 1'b0;
   logic [1:0]    cfg_perm = '0;
   logic [AW-1:0] cfg_base = '0;
   logic [AW-1:0] cfg_size = '0;
   logic          acc_valid = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic          acc_write = 1'b0;
   logic          rsp_valid, rsp_grant, rsp_fault, rsp_hit, flt_write;
   logic [2:0]    rsp_idx;
   logic [AW-1:0] flt_addr;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mpc_checker u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_perm(cfg_perm),
      .cfg_base(cfg_base), .cfg_size(cfg_size),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
      .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
      .rsp_hit(rsp_hit), .rsp_idx(rsp_idx), .flt_addr(flt_addr), .flt_write(flt_write)
   );

   // vector: {addr, write, grant, hit, idx}
   localparam logic [37:0] VEC [NV] = '{
      {32'h0000_1000, 1'b0, 1'b1, 1'b1, 3'd0},  // R2 window start
      {32'h0000_1FFF, 1'b1, 1'b1, 1'b1, 3'd0},  // R2 last byte, R3 rw
      {32'h0000_2000, 1'b0, 1'b1, 1'b1, 3'd1},  // R3 read-only read
      {32'h0000_20FF, 1'b1, 1'b0, 1'b1, 3'd1},  // R3 read-only write
      {32'h0000_2100, 1'b0, 1'b0, 1'b0, 3'd0},  // R2 end is exclusive, R5
      {32'h0000_3000, 1'b0, 1'b0, 1'b1, 3'd2},  // R3 code 00
      {32'h0000_1800, 1'b0, 1'b1, 1'b1, 3'd3},  // R4 overlap read
      {32'h0000_1800, 1'b1, 1'b0, 1'b1, 3'd3},  // R4 higher window refuses write
      {32'h0000_17FF, 1'b1, 1'b1, 1'b1, 3'd0},  // R4 below overlap
      {32'h0000_4010, 1'b0, 1'b0, 1'b1, 3'd4},  // R3 code 11
      {32'h0000_5000, 1'b0, 1'b0, 1'b0, 3'd0},  // R6 disabled window
      {32'h0000_600F, 1'b1, 1'b1, 1'b1, 3'd7},  // R2 window 7 last byte
      {32'h0000_0FFF, 1'b0, 1'b0, 1'b0, 3'd0}   // R5 below all
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_region(input int idx, input logic en, input logic [1:0] p,
                            input logic [AW-1:0] b, input logic [AW-1:0] s);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_en = en; cfg_perm = p;
      cfg_base = b; cfg_size = s;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // drives one request, returns at the negedge after the verdict is registered
   task automatic access(input logic [AW-1:0] a, input logic w);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_write = w;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
      check("R1 flt_addr", 64'(flt_addr), 64'd0);
      check("R1 flt_write", 64'(flt_write), 64'd0);
      access(32'h0000_1000, 1'b0);
      check("R1 fault after reset", 64'({rsp_valid, rsp_grant, rsp_fault, rsp_hit}), 64'b1010);
      // R7 idle cycle
      @(negedge clk);
      check("R7 idle", 64'({rsp_valid, rsp_grant, rsp_fault}), 64'd0);

      wr_region(0, 1'b1, 2'b10, 32'h1000, 32'h1000);
      wr_region(1, 1'b1, 2'b01, 32'h2000, 32'h100);
      wr_region(2, 1'b1, 2'b00, 32'h3000, 32'h100);
      wr_region(3, 1'b1, 2'b01, 32'h1800, 32'h100);
      wr_region(4, 1'b1, 2'b11, 32'h4000, 32'h100);
      wr_region(5, 1'b0, 2'b10, 32'h5000, 32'h100);
      wr_region(7, 1'b1, 2'b10, 32'h6000, 32'h10);

      for (int i = 0; i < NV; i++) begin
         logic [AW-1:0] a;
         logic w, g, h;
         logic [2:0] ix;
         {a, w, g, h, ix} = VEC[i];
         access(a, w);
         check("R7 valid", 64'(rsp_valid), 64'd1);
         check("R3 grant", 64'({rsp_grant, rsp_fault}), 64'({g, !g}));
         check("R4 hit/idx", 64'({rsp_hit, rsp_idx}), 64'({h, ix}));
         if (!g) check("R8 fault capture", 64'({flt_addr, flt_write}), 64'({a, w}));
      end

      // R8 hold through a grant
      access(32'h0000_3004, 1'b1);
      access(32'h0000_1004, 1'b0);
      check("R8 hold", 64'({flt_addr, flt_write}), 64'({32'h3004, 1'b1}));

      // R2 size zero never matches
      wr_region(6, 1'b1, 2'b10, 32'h7000, 32'h0);
      access(32'h0000_7000, 1'b0);
      check("R2 size zero", 64'({rsp_fault, rsp_hit}), 64'b10);

      // R9 same-cycle write sees old setting, next cycle sees new
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'd0; cfg_en = 1'b1; cfg_perm = 2'b01;
      cfg_base = 32'h1000; cfg_size = 32'h1000;
      acc_valid = 1'b1; acc_addr = 32'h1010; acc_write = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      check("R9 old setting", 64'(rsp_grant), 64'd1);
      @(negedge clk);
      acc_valid = 1'b0;
      check("R9 new setting", 64'({rsp_grant, rsp_fault}), 64'b01);

      // R6 disable a matching window
      wr_region(7, 1'b0, 2'b10, 32'h6000, 32'h10);
      access(32'h0000_6000, 1'b0);
      check("R6 disabled", 64'({rsp_fault, rsp_hit, rsp_idx}), 64'b1_0_000);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule